// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block monitors a wide set of general-purpose input pins (85 by default) and latches selected transitions into sticky per-pin status flags. Each pin passes through a synchroniser, and its synchronised value is compared with the value from the clock before. A transition counts only if software has enabled that direction for that pin. There is one rising-edge enable and one falling-edge enable per pin.

Software reaches the enables and the status flags through a simple 32-bit register bus. Pins are packed 32 to a bank, so the last bank is only partly filled. A status flag is cleared by writing a one to its position. Three registered interrupt requests leave the block. Pin 0 and pin 1 each have a request of their own. A third, shared request is active while any status flag from pin 2 upward is set.

Top module: `gpio_edge_irq`

## Requirements
- R1: Register map, with bank b holding pins 32*b to 32*b+31 and pin p at bit p%32: rising enables at 0x30+4*b, falling enables at 0x3C+4*b, status at 0x48+4*b, for b = 0..2. Other addresses read 0.
- R2: A pin's status bit becomes 1 on a rising edge only when that pin's rising enable is 1, and on a falling edge only when its falling enable is 1. An edge of a disabled direction, or no change at all, leaves the bit at 0.
- R3: With both enables set for a pin, either direction of transition sets its status bit.
- R4: A set status bit stays 1 through later edges and through the pin returning to its earlier level, until software clears it.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged, and clearing one bit leaves the other bits of the bank alone.
- R6: After a synchronous reset, all status bits, all enable bits and all three interrupt outputs are 0.
- R7: When a qualifying edge and a write-one-to-clear hit the same status bit in the same clock, the bit ends at 1.
- R8: irq_pin0 and irq_pin1 each follow their own pin's status bit, one clock later.
- R9: irq_shared is 1 one clock after any status bit of pins 2 to 84 is 1, and 0 one clock after all of them are 0.
- R10: Bits 21 to 31 of the third rising, falling and status banks read 0, and writes to them have no effect.
- R11: Enable registers read back the last value written. Read data is registered: it appears on bus_rdata on the clock after bus_rd_en is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous general-purpose inputs |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_pin0 | output | 1 | Interrupt request for pin 0 |
| irq_pin1 | output | 1 | Interrupt request for pin 1 |
| irq_shared | output | 1 | Combined interrupt request for pins 2 and up |

## Verification
The hardest case to reach from the ports is a detected edge and a software clear landing on the same status bit in the same clock. The edge only becomes visible after the synchroniser and the one-clock history register. The bench therefore changes the pin, counts two clock edges, and issues the clear write so that it is sampled on the third edge. The flag must still read 1 afterwards, and a later plain clear must drop it. A table of single-pin transitions also covers enabled, disabled and both-direction edges on pins in all three banks, including the last pin of the partly filled bank.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // kind of register addressed on the bus
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RISE = 2'd1,
    REG_FALL = 2'd2,
    REG_STAT = 2'd3
  } reg_kind_e;

  // first rising-enable bank; falling and status banks follow contiguously
  localparam int RISE_BASE = 'h30;
  localparam int REG_BYTES = 4;

  function automatic int bank_count(input int pins, input int width);
    return (pins + width - 1) / width;
  endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NUM_PINS    = 85,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);

  logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];
  logic [NUM_PINS-1:0] prev_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign rise_o = stage_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~stage_q[SYNC_STAGES-1] & prev_q;

endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NBANK  = 3,
  parameter int BANK_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BANK_W-1:0] bank
);

  localparam int SPAN = 3 * NBANK * REG_BYTES;

  int a_int;
  int idx;

  always_comb begin
    a_int = int'(addr);
    idx   = 0;
    kind  = REG_NONE;
    bank  = '0;
    if (a_int >= RISE_BASE && a_int < RISE_BASE + SPAN && (a_int % REG_BYTES) == 0) begin
      idx  = (a_int - RISE_BASE) / REG_BYTES;
      kind = reg_kind_e'(2'(1 + idx / NBANK));
      bank = BANK_W'(idx % NBANK);
    end
  end

endmodule

// File: rtl/gpio_enable_bank.sv
module gpio_enable_bank #(
  parameter int NUM_PINS = 85,
  parameter int DATA_W   = 32,
  parameter int BANK_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [BANK_W-1:0]   bank_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] en_q
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        en_q[i] <= 1'b0;
      else if (wr_en && bank_sel == BANK_W'(i / DATA_W))
        en_q[i] <= wdata[i % DATA_W];
    end
  end

endmodule

// File: rtl/gpio_status_bank.sv
module gpio_status_bank #(
  parameter int NUM_PINS = 85,
  parameter int DATA_W   = 32,
  parameter int BANK_W   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic                clr_wr,
  input  logic [BANK_W-1:0]   bank_sel,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PINS-1:0] clr_mask_o,
  output logic [NUM_PINS-1:0] status_q
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    assign clr_mask_o[i] = clr_wr && (bank_sel == BANK_W'(i / DATA_W)) && wdata[i % DATA_W];

    // a new edge takes priority over a clear in the same clock
    always_ff @(posedge clk) begin
      if (rst)              status_q[i] <= 1'b0;
      else if (set_i[i])    status_q[i] <= 1'b1;
      else if (clr_mask_o[i]) status_q[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen #(
  parameter int NUM_PINS = 85
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] status_i,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared
);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pin0   <= 1'b0;
      irq_pin1   <= 1'b0;
      irq_shared <= 1'b0;
    end else begin
      irq_pin0   <= status_i[0];
      irq_pin1   <= status_i[1];
      irq_shared <= |status_i[NUM_PINS-1:2];
    end
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 85,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_pin0,
  output logic                irq_pin1,
  output logic                irq_shared
);

  localparam int NBANK  = bank_count(NUM_PINS, DATA_W);
  localparam int PAD_W  = NBANK * DATA_W;
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  reg_kind_e           kind;
  logic [BANK_W-1:0]   bank;
  logic [NUM_PINS-1:0] rise_edge, fall_edge;
  logic [NUM_PINS-1:0] rise_en, fall_en;
  logic [NUM_PINS-1:0] set_mask, clr_mask, status_q;
  logic [PAD_W-1:0]    rise_pad, fall_pad, stat_pad;

  gpio_reg_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
    .addr (bus_addr),
    .kind (kind),
    .bank (bank)
  );

  gpio_pin_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (pin_i),
    .rise_o (rise_edge),
    .fall_o (fall_edge)
  );

  gpio_enable_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_rise (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en && kind == REG_RISE),
    .bank_sel (bank),
    .wdata    (bus_wdata),
    .en_q     (rise_en)
  );

  gpio_enable_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_fall (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr_en && kind == REG_FALL),
    .bank_sel (bank),
    .wdata    (bus_wdata),
    .en_q     (fall_en)
  );

  assign set_mask = (rise_edge & rise_en) | (fall_edge & fall_en);

  gpio_status_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_i      (set_mask),
    .clr_wr     (bus_wr_en && kind == REG_STAT),
    .bank_sel   (bank),
    .wdata      (bus_wdata),
    .clr_mask_o (clr_mask),
    .status_q   (status_q)
  );

  gpio_irq_gen #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .status_i   (status_q),
    .irq_pin0   (irq_pin0),
    .irq_pin1   (irq_pin1),
    .irq_shared (irq_shared)
  );

  // unpopulated bits of the last bank read as zero
  assign rise_pad = PAD_W'(rise_en);
  assign fall_pad = PAD_W'(fall_en);
  assign stat_pad = PAD_W'(status_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd_en) begin
      case (kind)
        REG_RISE: bus_rdata <= rise_pad[int'(bank) * DATA_W +: DATA_W];
        REG_FALL: bus_rdata <= fall_pad[int'(bank) * DATA_W +: DATA_W];
        REG_STAT: bus_rdata <= stat_pad[int'(bank) * DATA_W +: DATA_W];
        default:  bus_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS = 85
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] status_q,
  input logic [NUM_PINS-1:0] set_mask,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic                irq_pin0,
  input logic                irq_pin1,
  input logic                irq_shared
);

  // R2: a status bit only rises when an enabled edge was seen
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(set_mask)) == '0));

  // R4: a set bit survives unless a clear was written
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status_q) & ~$past(clr_mask) & ~status_q) == '0));

  // R6: reset empties the status and the requests
  a_r6_reset_clear: assert property (@(posedge clk)
    rst |=> (status_q == '0) && !irq_pin0 && !irq_pin1 && !irq_shared);

  // R7: an edge coinciding with a clear leaves the bit set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(set_mask) & ~status_q) == '0));

  // R8: dedicated requests follow their status bits
  a_r8_pin_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_pin0 == $past(status_q[0])) && (irq_pin1 == $past(status_q[1])));

  // R9: shared request tracks the upper pins
  a_r9_shared_irq: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_shared == $past(|status_q[NUM_PINS-1:2])));

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .status_q   (status_q),
  .set_mask   (set_mask),
  .clr_mask   (clr_mask),
  .irq_pin0   (irq_pin0),
  .irq_pin1   (irq_pin1),
  .irq_shared (irq_shared)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PINS   = 85;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [NUM_PINS-1:0] pins = '0;
  logic                wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]          addr = '0;
  logic [31:0]         wdata = '0;
  logic [31:0]         rdata;
  logic                irq0, irq1, irqs;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq u_dut (
    .clk(clk), .rst(rst), .pin_i(pins),
    .bus_wr_en(wr_en), .bus_rd_en(rd_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_pin0(irq0), .irq_pin1(irq1), .irq_shared(irqs)
  );

  // vector: {pin[6:0], rise_en, fall_en, from_level, to_level, expect}
  localparam logic [11:0] VEC [9] = '{
    {7'd0,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'd1,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {7'd40, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    {7'd63, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {7'd64, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {7'd84, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {7'd33, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {7'd20, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6 / R1: everything reads zero after reset, unmapped address too
    for (int b = 0; b < 3; b++) begin
      rd(8'(8'h30 + 4*b), d); check("R6 rise reset", d, 0);
      rd(8'(8'h3C + 4*b), d); check("R6 fall reset", d, 0);
      rd(8'(8'h48 + 4*b), d); check("R6 status reset", d, 0);
    end
    check("R6 irqs reset", {29'd0, irq0, irq1, irqs}, 0);
    rd(8'h54, d); check("R1 unmapped reads 0", d, 0);

    // R11 / R1: enable readback per bank
    wr(8'h30, 32'hA5A5_0F0F); wr(8'h3C, 32'h1234_5678); wr(8'h40, 32'hDEAD_BEEF);
    rd(8'h30, d); check("R11 rise bank0 readback", d, 32'hA5A5_0F0F);
    rd(8'h3C, d); check("R11 fall bank0 readback", d, 32'h1234_5678);
    rd(8'h40, d); check("R1 fall bank1 readback", d, 32'hDEAD_BEEF);
    rd(8'h34, d); check("R1 rise bank1 untouched", d, 0);

    // R10: top bank only 21 bits wide
    wr(8'h38, 32'hFFFF_FFFF); wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h38, d); check("R10 rise bank2 width", d, 32'h001F_FFFF);
    rd(8'h44, d); check("R10 fall bank2 width", d, 32'h001F_FFFF);
    for (int b = 0; b < 3; b++) begin
      wr(8'(8'h30 + 4*b), 0); wr(8'(8'h3C + 4*b), 0);
    end

    // R2 / R3 / R8 / R9 / R1: table of single-pin transitions
    for (int v = 0; v < 9; v++) begin
      int p; int bk; logic [7:0] sa;
      p  = int'(VEC[v][11:5]);
      bk = p / 32;
      sa = 8'(8'h48 + 4*bk);
      @(negedge clk); pins[p] = VEC[v][2];
      wait_clk(5);
      wr(sa, 32'hFFFF_FFFF);
      wr(8'(8'h30 + 4*bk), 32'(VEC[v][4]) << (p % 32));
      wr(8'(8'h3C + 4*bk), 32'(VEC[v][3]) << (p % 32));
      @(negedge clk); pins[p] = VEC[v][1];
      wait_clk(5);
      rd(sa, d);
      check($sformatf("R2 R3 status pin %0d", p), d, 32'(VEC[v][0]) << (p % 32));
      if (p == 0)      check("R8 irq_pin0", 32'(irq0), 32'(VEC[v][0]));
      else if (p == 1) check("R8 irq_pin1", 32'(irq1), 32'(VEC[v][0]));
      else             check($sformatf("R9 irq_shared pin %0d", p), 32'(irqs), 32'(VEC[v][0]));
      wr(8'(8'h30 + 4*bk), 0); wr(8'(8'h3C + 4*bk), 0);
      wr(sa, 32'hFFFF_FFFF);
      @(negedge clk); pins[p] = 1'b0;
      wait_clk(5);
      wr(sa, 32'hFFFF_FFFF);
    end
    wait_clk(2);
    check("R9 irqs idle after table", {29'd0, irq0, irq1, irqs}, 0);

    // R4 / R5: stickiness and write-one-to-clear on pin 10
    wr(8'h30, 32'h0000_0400);
    @(negedge clk); pins[10] = 1'b1; wait_clk(5);
    @(negedge clk); pins[10] = 1'b0; wait_clk(5);
    rd(8'h48, d); check("R4 sticky after pin returns", d, 32'h0000_0400);
    wr(8'h48, 32'h0000_0000);
    rd(8'h48, d); check("R5 zero write no effect", d, 32'h0000_0400);
    wr(8'h48, 32'h0000_0800);
    rd(8'h48, d); check("R5 other bit clear no effect", d, 32'h0000_0400);
    wait_clk(1);
    check("R9 shared high while set", 32'(irqs), 1);
    wr(8'h48, 32'h0000_0400);
    rd(8'h48, d); check("R5 write one clears", d, 0);
    wait_clk(1);
    check("R9 shared low after clear", 32'(irqs), 0);

    // R7: edge and clear in the same clock on pin 12
    wr(8'h30, 32'h0000_1000); wr(8'h3C, 32'h0000_1000);
    @(negedge clk); pins[12] = 1'b1; wait_clk(5);
    @(negedge clk); pins[12] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); wr_en = 1'b1; addr = 8'h48; wdata = 32'h0000_1000;
    @(posedge clk); #1; wr_en = 1'b0;
    rd(8'h48, d); check("R7 set wins over clear", d, 32'h0000_1000);
    wr(8'h48, 32'h0000_1000);
    rd(8'h48, d); check("R7 later clear works", d, 0);

    // R10: status top bank ignores writes to bits above 20
    wr(8'h38, 32'h0010_0000);
    @(negedge clk); pins[84] = 1'b1; wait_clk(5);
    wr(8'h50, 32'hFFE0_0000);
    rd(8'h50, d); check("R10 status bank2 upper clear ignored", d, 32'h0010_0000);

    // R6: reset mid-run clears status and enables
    @(negedge clk); rst = 1'b1; wait_clk(2);
    @(negedge clk); rst = 1'b0;
    rd(8'h50, d); check("R6 status cleared by reset", d, 0);
    rd(8'h38, d); check("R6 enable cleared by reset", d, 0);
    check("R6 irqs after reset", {29'd0, irq0, irq1, irqs}, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule